// File: doc/BRIEF.md
# Hot-Page Pending Queue with Interrupt

This block keeps a short list of memory pages that the miss counters of a memory node have marked as hot. Each node has one instance of the block. A hot-page event arrives with a local page number, the home node of the page, the node and CPU that requested it, and a routing mode. The block decides whether the event belongs to its own node, forms the page number for that mode, and places it in a fixed array of slots. Each slot holds either a page or a reserved empty marker.

Insertion walks the slots from the lowest index. It stops at the first slot that is either empty or already holds the same page. An empty slot takes the page. A matching slot means the event is dropped. If no slot qualifies, the page is lost and a one-cycle overflow flag is raised. Once the number of pending pages reaches a threshold, the block raises an interrupt towards a chosen CPU.

Software drains the list one page per request. Each request returns the lowest-index occupied page and frees that slot. The interrupt is withdrawn only when a pop leaves the list empty.

Top module: `hpq_queue`

## Requirements
- R1: After reset every slot is empty, `pend_count` is 0, and `irq` and `ovf` are 0. A pop on the freshly reset block returns page 0.
- R2: An accepted event whose scan reaches an empty slot first stores the page in that slot, and `pend_count` rises by 1 in the following cycle.
- R3: An event whose page already sits in a slot below the first empty slot is dropped, and the count is unchanged. If an empty slot comes before the matching slot, the page is stored again as a second copy.
- R4: When a store leaves the count at or above `IRQ_THRESH` (default 4), `irq` is 1 from the next cycle and `irq_cpu` holds the event's target CPU.
- R5: An accepted event that finds neither an empty slot nor a match drives `ovf` high for exactly one cycle. The page is discarded and the count stays at `NUM_SLOTS` (default 8).
- R6: A pop answers one cycle later with `pop_valid`=1 and `pop_page` set to the page of the lowest-index occupied slot. That slot becomes empty and the count falls by 1. A pop on an empty list returns 0 and leaves the count at 0.
- R7: `irq` stays high while pages remain and drops in the cycle after a pop leaves the count at 0.
- R8: When `ev_to_req`=1 the event is accepted only if `ev_req_node` equals `NODE_ID`. The stored page is `ev_lpage + 1024*ev_home` (the stripe is 1024 pages), and the target CPU is `ev_req_cpu`.
- R9: When `ev_to_req`=0 the event is accepted only if `ev_home` equals `NODE_ID`. The stored page is `ev_lpage`, and the target CPU is `NODE_ID*CPUS_PER_NODE` (CPU 2 by default, with `NODE_ID`=1). Events for other nodes leave every output unchanged.
- R10: An event and a pop in the same cycle are applied event first. The pop therefore sees the slots and count as they are after the insertion, including a page stored in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Hot-page event present |
| ev_to_req | input | 1 | 1: route to the requester's node with a global page; 0: route to the home node with the local page |
| ev_lpage | input | 10 | Page number local to the home stripe |
| ev_home | input | 2 | Home node of the page |
| ev_req_node | input | 2 | Node of the requesting CPU |
| ev_req_cpu | input | 3 | Requesting CPU |
| pop_req | input | 1 | Request to remove one pending page |
| pop_valid | output | 1 | Pop response, one cycle after `pop_req` |
| pop_page | output | 13 | Removed page, or 0 when the list was empty |
| pend_count | output | 4 | Number of occupied slots |
| irq | output | 1 | Interrupt towards `irq_cpu` |
| irq_cpu | output | 3 | CPU that the interrupt targets |
| ovf | output | 1 | One-cycle flag for a page lost to a full list |

## Verification
The bench targets these corner cases:
- A repeated page that sits behind an empty slot. A design that suppresses duplicates anywhere in the array would keep one copy instead of two.
- A ninth distinct page on a full list. A wrong design would overwrite a slot or let the count reach nine.
- An insert and a pop in the same cycle on an empty list. An ordering that runs the pop first would return 0 and leave a page behind.
- The exact cycle in which the count crosses the threshold, and the pop that empties the list. Here an off-by-one compare, or clearing the interrupt on a plain decrement, shows up at once.

Events addressed to other nodes are mixed in under both routing modes, so that a wrong accept test or a wrong page formula changes the count or the popped values.

// File: rtl/hpq_pkg.sv
package hpq_pkg;

    localparam int LPAGE_W      = 10;
    localparam int NODE_W       = 2;
    localparam int CPU_W        = 3;
    localparam int STRIPE_PAGES = 1 << LPAGE_W;
    // one spare bit so that no real global page can equal the empty marker
    localparam int PAGE_W       = LPAGE_W + NODE_W + 1;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [CPU_W-1:0]  cpu_t;
    typedef logic [NODE_W-1:0] node_t;

    localparam page_t EMPTY_PAGE = '1;

    typedef struct packed {
        logic  valid;
        page_t page;
        cpu_t  target;
    } hp_evt_t;

    function automatic page_t make_global(input logic [LPAGE_W-1:0] lpage, input node_t home);
        return page_t'(home) * page_t'(STRIPE_PAGES) + page_t'(lpage);
    endfunction

endpackage

// File: rtl/hpq_route.sv
module hpq_route
    import hpq_pkg::*;
#(
    parameter int NODE_ID       = 1,
    parameter int CPUS_PER_NODE = 2
) (
    input  logic               ev_valid,
    input  logic               ev_to_req,
    input  logic [LPAGE_W-1:0] ev_lpage,
    input  node_t              ev_home,
    input  node_t              ev_req_node,
    input  cpu_t               ev_req_cpu,
    output hp_evt_t            evt
);
    localparam node_t MY_NODE   = node_t'(NODE_ID);
    localparam cpu_t  FIRST_CPU = cpu_t'(NODE_ID * CPUS_PER_NODE);

    always_comb begin
        evt = '0;
        if (ev_to_req) begin
            evt.valid  = ev_valid && (ev_req_node == MY_NODE);
            evt.page   = make_global(ev_lpage, ev_home);
            evt.target = ev_req_cpu;
        end else begin
            evt.valid  = ev_valid && (ev_home == MY_NODE);
            evt.page   = page_t'(ev_lpage);
            evt.target = FIRST_CPU;
        end
    end
endmodule

// File: rtl/hpq_slots.sv
module hpq_slots
    import hpq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  hp_evt_t          evt,
    input  logic             pop_req,
    output logic             ins_stored,
    output logic             ins_lost,
    output logic [CNT_W-1:0] cnt_after_ins,
    output logic [CNT_W-1:0] cnt_after_pop,
    output logic             pop_valid,
    output page_t            pop_page,
    output logic [CNT_W-1:0] pend_count
);
    page_t            slots   [NUM_SLOTS];
    page_t            slots_a [NUM_SLOTS];
    page_t            slots_b [NUM_SLOTS];
    logic             found;
    logic             pop_hit;
    page_t            pop_val;

    // insertion stage: first slot that is empty or equal wins
    always_comb begin
        slots_a       = slots;
        cnt_after_ins = pend_count;
        found         = 1'b0;
        ins_stored    = 1'b0;
        ins_lost      = 1'b0;
        if (evt.valid) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (!found && (slots[i] == EMPTY_PAGE || slots[i] == evt.page)) begin
                    found = 1'b1;
                    if (slots[i] == EMPTY_PAGE) begin
                        slots_a[i] = evt.page;
                        ins_stored = 1'b1;
                    end
                end
            end
            ins_lost = !found;
            if (ins_stored)
                cnt_after_ins = pend_count + CNT_W'(1);
        end
    end

    // pop stage works on the post-insert view
    always_comb begin
        slots_b       = slots_a;
        cnt_after_pop = cnt_after_ins;
        pop_hit       = 1'b0;
        pop_val       = '0;
        if (pop_req) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (!pop_hit && slots_a[i] != EMPTY_PAGE) begin
                    pop_hit    = 1'b1;
                    pop_val    = slots_a[i];
                    slots_b[i] = EMPTY_PAGE;
                end
            end
            if (pop_hit)
                cnt_after_pop = cnt_after_ins - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= EMPTY_PAGE;
            pend_count <= '0;
            pop_valid  <= 1'b0;
            pop_page   <= '0;
        end else begin
            slots      <= slots_b;
            pend_count <= cnt_after_pop;
            pop_valid  <= pop_req;
            pop_page   <= pop_val;
        end
    end
endmodule

// File: rtl/hpq_irq.sv
module hpq_irq
    import hpq_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int IRQ_THRESH = 4,
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_stored,
    input  logic             ins_lost,
    input  cpu_t             target,
    input  logic [CNT_W-1:0] cnt_after_ins,
    input  logic             pop_req,
    input  logic [CNT_W-1:0] cnt_after_pop,
    output logic             irq,
    output cpu_t             irq_cpu,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(IRQ_THRESH);

    logic fire;
    assign fire = ins_stored && (cnt_after_ins >= THRESH);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            irq_cpu <= '0;
            ovf     <= 1'b0;
        end else begin
            ovf <= ins_lost;
            if (fire)
                irq_cpu <= target;
            if (pop_req && cnt_after_pop == '0)
                irq <= 1'b0;
            else if (fire)
                irq <= 1'b1;
        end
    end
endmodule

// File: rtl/hpq_queue.sv
module hpq_queue
    import hpq_pkg::*;
#(
    parameter int NUM_SLOTS     = 8,
    parameter int IRQ_THRESH    = 4,
    parameter int NODE_ID       = 1,
    parameter int CPUS_PER_NODE = 2,
    localparam int CNT_W        = $clog2(NUM_SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_valid,
    input  logic               ev_to_req,
    input  logic [LPAGE_W-1:0] ev_lpage,
    input  logic [NODE_W-1:0]  ev_home,
    input  logic [NODE_W-1:0]  ev_req_node,
    input  logic [CPU_W-1:0]   ev_req_cpu,
    input  logic               pop_req,
    output logic               pop_valid,
    output logic [PAGE_W-1:0]  pop_page,
    output logic [CNT_W-1:0]   pend_count,
    output logic               irq,
    output logic [CPU_W-1:0]   irq_cpu,
    output logic               ovf
);
    hp_evt_t          evt;
    logic             ins_stored;
    logic             ins_lost;
    logic [CNT_W-1:0] cnt_after_ins;
    logic [CNT_W-1:0] cnt_after_pop;

    hpq_route #(.NODE_ID(NODE_ID), .CPUS_PER_NODE(CPUS_PER_NODE)) u_route (
        .ev_valid    (ev_valid),
        .ev_to_req   (ev_to_req),
        .ev_lpage    (ev_lpage),
        .ev_home     (ev_home),
        .ev_req_node (ev_req_node),
        .ev_req_cpu  (ev_req_cpu),
        .evt         (evt)
    );

    hpq_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .pop_req       (pop_req),
        .ins_stored    (ins_stored),
        .ins_lost      (ins_lost),
        .cnt_after_ins (cnt_after_ins),
        .cnt_after_pop (cnt_after_pop),
        .pop_valid     (pop_valid),
        .pop_page      (pop_page),
        .pend_count    (pend_count)
    );

    hpq_irq #(.NUM_SLOTS(NUM_SLOTS), .IRQ_THRESH(IRQ_THRESH)) u_irq (
        .clk           (clk),
        .rst           (rst),
        .ins_stored    (ins_stored),
        .ins_lost      (ins_lost),
        .target        (evt.target),
        .cnt_after_ins (cnt_after_ins),
        .pop_req       (pop_req),
        .cnt_after_pop (cnt_after_pop),
        .irq           (irq),
        .irq_cpu       (irq_cpu),
        .ovf           (ovf)
    );
endmodule

// File: rtl/hpq_checker.sv
module hpq_checker #(
    parameter int NUM_SLOTS  = 8,
    parameter int IRQ_THRESH = 4,
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic             pop_req,
    input logic             pop_valid,
    input logic [CNT_W-1:0] pend_count,
    input logic             irq,
    input logic             ovf
);
    // R5: the count never exceeds the slot total
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        pend_count <= CNT_W'(NUM_SLOTS));

    // R2 / R6: one insert and one pop per cycle move the count by at most one
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (pend_count == $past(pend_count)) ||
        (pend_count == $past(pend_count) + CNT_W'(1)) ||
        (pend_count == $past(pend_count) - CNT_W'(1)));

    // R4: the interrupt only rises right after an event
    a_r4_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ev_valid));

    // R7: an asserted interrupt always has pages behind it
    a_r7_irq_has_pages: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend_count != '0);

    // R5: overflow is reported only after an event
    a_r5_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(ev_valid));

    // R6: a response follows exactly the cycle after a request
    a_r6_pop_resp: assert property (@(posedge clk) disable iff (rst)
        pop_valid == $past(pop_req));
endmodule

bind hpq_queue hpq_checker #(.NUM_SLOTS(NUM_SLOTS), .IRQ_THRESH(IRQ_THRESH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .pend_count (pend_count),
    .irq        (irq),
    .ovf        (ovf)
);

// File: tb/sim_hpq_queue.sv
`timescale 1ns/1ps
module sim_hpq_queue;
    localparam int NSLOT = 8;
    localparam int THR   = 4;
    localparam int NODE  = 1;
    localparam int FCPU  = 2;
    localparam int EMPTY = 8191;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic        ev_to_req = 1'b0;
    logic [9:0]  ev_lpage = '0;
    logic [1:0]  ev_home = '0;
    logic [1:0]  ev_req_node = '0;
    logic [2:0]  ev_req_cpu = '0;
    logic        pop_req = 1'b0;
    logic        pop_valid;
    logic [12:0] pop_page;
    logic [3:0]  pend_count;
    logic        irq;
    logic [2:0]  irq_cpu;
    logic        ovf;

    int total = 0;
    int bad   = 0;

    int m_slot [NSLOT];
    int m_cnt;
    bit m_irq;
    int m_cpu;
    bit m_ovf;
    int m_pop;

    always #2 clk = ~clk;

    hpq_queue u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_to_req(ev_to_req),
        .ev_lpage(ev_lpage), .ev_home(ev_home), .ev_req_node(ev_req_node),
        .ev_req_cpu(ev_req_cpu), .pop_req(pop_req), .pop_valid(pop_valid),
        .pop_page(pop_page), .pend_count(pend_count), .irq(irq),
        .irq_cpu(irq_cpu), .ovf(ovf)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // called at a negedge; applies one cycle of stimulus and checks results
    task automatic step(input bit ev, input bit mode, input int lp, input int home,
                        input int rn, input int rc, input bit pop, input string tag);
        bit acc, found, stored;
        int page, cpu;
        ev_valid = ev; ev_to_req = mode; ev_lpage = 10'(lp); ev_home = 2'(home);
        ev_req_node = 2'(rn); ev_req_cpu = 3'(rc); pop_req = pop;
        if (mode) begin
            acc = (rn == NODE); page = lp + 1024 * home; cpu = rc;
        end else begin
            acc = (home == NODE); page = lp; cpu = FCPU;
        end
        m_ovf = 0; found = 0; stored = 0;
        if (ev && acc) begin
            for (int i = 0; i < NSLOT; i++)
                if (!found && (m_slot[i] == EMPTY || m_slot[i] == page)) begin
                    found = 1;
                    if (m_slot[i] == EMPTY) begin m_slot[i] = page; stored = 1; m_cnt++; end
                end
            m_ovf = !found;
            if (stored && m_cnt >= THR) begin m_irq = 1; m_cpu = cpu; end
        end
        m_pop = 0;
        if (pop) begin
            found = 0;
            for (int i = 0; i < NSLOT; i++)
                if (!found && m_slot[i] != EMPTY) begin
                    found = 1; m_pop = m_slot[i]; m_slot[i] = EMPTY; m_cnt--;
                end
            if (m_cnt == 0) m_irq = 0;
        end
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0; pop_req = 1'b0;
        check(tag, "pend_count", int'(pend_count), m_cnt);
        check(tag, "irq", int'(irq), int'(m_irq));
        check(tag, "ovf", int'(ovf), int'(m_ovf));
        if (m_irq) check(tag, "irq_cpu", int'(irq_cpu), m_cpu);
        check(tag, "pop_valid", int'(pop_valid), int'(pop));
        if (pop) check(tag, "pop_page", int'(pop_page), m_pop);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSLOT; i++) m_slot[i] = EMPTY;
        m_cnt = 0; m_irq = 0; m_cpu = 0; m_ovf = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "pend_count", int'(pend_count), 0);
        check("R1", "irq", int'(irq), 0);
        check("R1", "ovf", int'(ovf), 0);
        check("R1", "pop_valid", int'(pop_valid), 0);
        step(0, 0, 0, 0, 0, 0, 1, "R1");
        step(0, 0, 0, 0, 0, 0, 1, "R6");

        // R2/R4/R9: fill in home mode, interrupt at fourth page
        for (int k = 0; k < NSLOT; k++)
            step(1, 0, 10 + k, NODE, 0, 0, 0, (k == THR - 1) ? "R4" : "R2");
        // R5: ninth distinct page is lost
        step(1, 0, 99, NODE, 0, 0, 0, "R5");
        step(1, 0, 100, NODE, 0, 0, 0, "R5");
        // R3: duplicate of a stored page on a full list is simply dropped
        step(1, 0, 12, NODE, 0, 0, 0, "R3");
        // R6/R7: drain in slot order; interrupt clears at zero
        for (int k = 0; k < NSLOT; k++) step(0, 0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 1, "R6");

        // R9: other home ignored; R8: other requester node ignored
        step(1, 0, 5, 2, 0, 0, 0, "R9");
        step(1, 1, 5, 1, 0, 5, 0, "R8");
        // R8: requester mode, global page numbers and requester CPU target
        for (int k = 0; k < THR; k++) step(1, 1, 5 + k, 3 - k, NODE, 3, 0, "R8");
        for (int k = 0; k < THR; k++) step(0, 0, 0, 0, 0, 0, 1, "R8");

        // R3: duplicate behind an empty slot is stored again
        step(1, 0, 40, NODE, 0, 0, 0, "R3");
        step(1, 0, 40, NODE, 0, 0, 0, "R3");
        step(1, 0, 41, NODE, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 1, "R3");
        step(1, 0, 41, NODE, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, 0, 0, 1, "R3");

        // R10: same-cycle insert and pop on an empty list
        step(1, 0, 77, NODE, 0, 0, 1, "R10");
        // R10: reaching threshold while popping keeps interrupt up
        for (int k = 0; k < THR - 1; k++) step(1, 0, 60 + k, NODE, 0, 0, 0, "R10");
        step(1, 1, 9, 2, NODE, 6, 1, "R10");
        for (int k = 0; k < THR - 1; k++) step(0, 0, 0, 0, 0, 0, 1, "R7");

        // sweep: mixed modes, nodes, repeats and pops
        for (int k = 0; k < 400; k++)
            step((k % 5) != 4, (k % 3) == 0, (k * 7) % 13, k % 4, (k / 3) % 3, k % 8,
                 (k % 4) == 1 || (k % 11) == 0, "R2");
        for (int k = 0; k < NSLOT + 1; k++) step(0, 0, 0, 0, 0, 0, 1, "R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule